// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked on-chip requester and an external asynchronous static RAM with 17 address bits and byte-wide data. Each accepted request becomes one complete read or write sequence on the memory pins. The request side uses a valid/ready handshake. Read data comes back on a one-cycle valid strobe. On the memory side the block drives an address bus, a pair of chip selects of opposite polarity, an active-low output enable and an active-low write enable. The shared data bus is split into an outgoing data word, a drive enable and an incoming data word, so the tristate buffer can be placed at the pad.

Every timing limit of the memory is a parameter in nanoseconds. Each limit becomes a number of clock cycles by rounding up against the clock-period parameter, and every phase lasts at least one cycle. A write opens with a setup phase, then a write-enable pulse, then a hold phase. The write ends when write enable rises while both chip selects stay asserted. A read holds output enable low for the access time and then spends a turnaround phase with the memory bus released. A later write therefore never drives data into a memory that is still driving.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `req_ready`=1 and `rd_valid`=0. Asserting reset in the middle of a write pulse raises `mem_we_n` at once.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the next cycle until the sequence ends. That is 5 cycles for a write and 6 cycles for a read at default parameters. Requests presented while `req_ready` is low have no effect on the memory.
- R3: During a write, `mem_we_n` is low for exactly PW cycles, where PW is the largest of the write-pulse, data-setup and address-to-write-end times, each rounded up (3 cycles at default parameters). It is low only while `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=1 and `mem_dq_oe`=1.
- R4: `mem_addr` and `mem_dq_out` stay constant for the whole of a sequence. When `mem_we_n` rises, both chip selects are still asserted and data is still driven for at least one more cycle.
- R5: Before `mem_we_n` falls, the chip selects, address and data are applied for the rounded address-setup time (1 cycle at default parameters).
- R6: A read holds `mem_oe_n` low, with chip selects asserted and `mem_we_n`=1, for RD cycles. RD is the largest of the access, output-enable-access and cycle times, rounded up (4 cycles at default parameters). `mem_dq_in` is sampled on the last clock of that phase. `rd_data` is then presented with `rd_valid` high for exactly one cycle, the 5th cycle after acceptance.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, at least TURN+1 cycles (3 at default parameters) pass with `mem_oe_n`=1 and the bus released before `mem_dq_oe` rises again. TURN is the rounded output-turn-off time.
- R8: Whenever `req_ready` is high, the memory is deselected, `mem_we_n`=1 and `mem_dq_oe`=0.
- R9: If a write is shorter than the rounded cycle time, the hold phase is stretched to make up the difference. Every phase count is the time rounded up to whole clock periods, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The hardest case to reach is a write that directly follows a read, because that is where bus turnaround matters. The stimulus table places such writes right after reads, with the next request already queued. The bench measures how many released cycles separate the fall of output enable's active phase from the rise of the data drive enable. A second hard case is a request that changes while the sequencer is busy. It is produced by changing the address and data and holding valid high in the middle of a write, then reading both addresses back. A reset asserted in the middle of a write pulse covers the asynchronous release of write enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic drv;
  } pins_t;

  localparam pins_t PINS_OFF = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

  // round a nanosecond figure up to whole clock periods, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_C   = 4,
  parameter int TURN_C = 2,
  parameter int SU_C   = 1,
  parameter int PW_C   = 3,
  parameter int HD_C   = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_write,
  output logic  req_ready,
  output logic  accept,
  output logic  capture,
  output pins_t pins_q
);

  localparam int MAXC  = imax(imax(RD_C, TURN_C), imax(imax(SU_C, PW_C), HD_C));
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] RD_L   = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] TURN_L = CNT_W'(TURN_C - 1);
  localparam logic [CNT_W-1:0] SU_L   = CNT_W'(SU_C - 1);
  localparam logic [CNT_W-1:0] PW_L   = CNT_W'(PW_C - 1);
  localparam logic [CNT_W-1:0] HD_L   = CNT_W'(HD_C - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pins_t            pins_d;

  function automatic pins_t decode(input phase_e st);
    pins_t p;
    p = PINS_OFF;
    case (st)
      ST_READ: begin
        p.ce_n = 1'b0; p.ce = 1'b1; p.oe_n = 1'b0;
      end
      ST_WSETUP, ST_WHOLD: begin
        p.ce_n = 1'b0; p.ce = 1'b1; p.drv = 1'b1;
      end
      ST_WPULSE: begin
        p.ce_n = 1'b0; p.ce = 1'b1; p.drv = 1'b1; p.we_n = 1'b0;
      end
      default: p = PINS_OFF;
    endcase
    return p;
  endfunction

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
            cnt_d   = SU_L;
          end else begin
            state_d = ST_READ;
            cnt_d   = RD_L;
          end
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = ST_TURN;
          cnt_d   = TURN_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_WSETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_WPULSE;
          cnt_d   = PW_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt_q == '0) begin
          state_d = ST_WHOLD;
          cnt_d   = HD_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    pins_d = decode(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pins_q  <= PINS_OFF;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pins_q  <= pins_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.drv |-> pins_q.oe_n);  // R7
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.we_n |-> (!pins_q.ce_n && pins_q.ce && pins_q.oe_n && pins_q.drv));  // R3
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pins_q.ce_n && !pins_q.ce && pins_q.we_n && !pins_q.drv));  // R8
  AST_WE_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.we_n) |-> (!pins_q.ce_n && pins_q.ce && pins_q.drv));  // R4
  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!pins_q.oe_n && !pins_q.ce_n));  // R6

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              rd_valid_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] rd_data_d;

  always_comb begin
    addr_d    = accept  ? req_addr  : addr_q;
    wdata_d   = accept  ? req_wdata : wdata_q;
    rd_data_d = capture ? mem_dq_in : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      wdata_q    <= wdata_d;
      rd_data_q  <= rd_data_d;
      rd_valid_q <= capture;
    end
  end

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |=> !rd_valid_q);  // R6

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W           = 17,
  parameter int DATA_W           = 8,
  parameter int CLK_PERIOD_NS    = 4,
  parameter int T_CYCLE_NS       = 15,
  parameter int T_ACCESS_NS      = 15,
  parameter int T_OE_ACCESS_NS   = 7,
  parameter int T_OE_HIZ_NS      = 7,
  parameter int T_ADDR_SU_NS     = 0,
  parameter int T_ADDR_TO_END_NS = 12,
  parameter int T_WE_PULSE_NS    = 12,
  parameter int T_DATA_SU_NS     = 8,
  parameter int T_ADDR_HOLD_NS   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CYC_C  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int SU_C   = ns_to_cyc(T_ADDR_SU_NS, CLK_PERIOD_NS);
  localparam int PW_C   = imax(ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                               imax(ns_to_cyc(T_DATA_SU_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_ADDR_TO_END_NS, CLK_PERIOD_NS)));
  localparam int HD_C   = imax(ns_to_cyc(T_ADDR_HOLD_NS, CLK_PERIOD_NS), CYC_C - SU_C - PW_C);
  localparam int RD_C   = imax(ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS),
                               imax(ns_to_cyc(T_OE_ACCESS_NS, CLK_PERIOD_NS), CYC_C));
  localparam int TURN_C = ns_to_cyc(T_OE_HIZ_NS, CLK_PERIOD_NS);

  logic  accept;
  logic  capture;
  pins_t pins_q;

  sram_ctrl_seq #(
    .RD_C   (RD_C),
    .TURN_C (TURN_C),
    .SU_C   (SU_C),
    .PW_C   (PW_C),
    .HD_C   (HD_C)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .pins_q    (pins_q)
  );

  sram_ctrl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .rd_data_q  (rd_data),
    .rd_valid_q (rd_valid)
  );

  assign mem_ce_n  = pins_q.ce_n;
  assign mem_ce    = pins_q.ce;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_dq_oe = pins_q.drv;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));  // R4

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int n_tests = 0;
  int n_fail  = 0;

  sram_async_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_ce (mem_ce),
    .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
    .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory model, indexed by the low ten address bits
  logic [7:0] model [0:1023];
  bit         model_ready = 0;
  assign mem_dq_in = (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) ? model[mem_addr[9:0]] : 8'h00;

  // pin monitor, sampled mid-cycle
  bit          prev_we_n = 1, prev_oe_n = 1, prev_dq_oe = 0;
  int          we_run = 0, we_rec = 0, su_cnt = 0, su_rec = 0;
  int          oe_run = 0, oe_rec = 0, gap_cnt = 1000, gap_rec = 0;
  bit          rise_ok = 0, contention = 0;
  logic [16:0] fall_addr;
  logic [7:0]  fall_data;

  always @(negedge clk) begin
    if (!model_ready) begin
      for (int i = 0; i < 1024; i++) model[i] = 8'h00;
      model_ready = 1;
    end
    if (mem_dq_oe && !mem_oe_n) contention = 1;
    if (!mem_ce_n && mem_we_n) su_cnt++;
    else if (mem_ce_n) su_cnt = 0;
    if (!mem_we_n) begin
      if (prev_we_n) begin
        fall_addr = mem_addr; fall_data = mem_dq_out; su_rec = su_cnt; we_run = 0;
      end
      we_run++;
      if (!mem_ce_n && mem_ce) model[mem_addr[9:0]] = mem_dq_out;
    end else if (!prev_we_n) begin
      we_rec  = we_run;
      rise_ok = !mem_ce_n && mem_ce && mem_dq_oe && (mem_addr == fall_addr) && (mem_dq_out == fall_data);
    end
    if (!mem_oe_n) begin
      oe_run++; gap_cnt = 0;
    end else begin
      if (!prev_oe_n) oe_rec = oe_run;
      oe_run = 0;
      if (!mem_dq_oe) gap_cnt++;
    end
    if (mem_dq_oe && !prev_dq_oe) gap_rec = gap_cnt;
    prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one full request; returns busy cycles, read latency and read data
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       output int busy, output int lat, output logic [7:0] rdat);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; lat = 0; rdat = 8'h00;
    while (!req_ready) begin
      if (rd_valid) begin lat = n; rdat = rd_data; end
      n++;
      @(negedge clk);
    end
    busy = n - 1;
  endtask

  // {write, address, data}; for reads data is the expected value
  localparam logic [25:0] VEC [0:11] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b0, 17'h00000, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h00155, 8'hFF},
    {1'b1, 17'h002AA, 8'h00},
    {1'b0, 17'h00155, 8'hFF},
    {1'b1, 17'h00155, 8'h5A},
    {1'b0, 17'h00155, 8'h5A},
    {1'b0, 17'h002AA, 8'h00},
    {1'b1, 17'h00001, 8'h81},
    {1'b0, 17'h00001, 8'h81}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int busy, lat;
    logic [7:0] rdat;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk("R1 reset pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset pins", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    chk("R1 ready/valid", {req_ready, rd_valid}, 2'b10);

    for (int i = 0; i < 12; i++) begin
      bit wr;
      wr = VEC[i][25];
      do_op(wr, VEC[i][24:8], VEC[i][7:0], busy, lat, rdat);
      chk(wr ? "R2 R9 write busy" : "R2 R9 read busy", busy, wr ? 5 : 6);
      if (wr) begin
        chk("R3 we pulse", we_rec, 3);
        chk("R5 setup", su_rec, 1);
        chk("R4 end hold", rise_ok, 1);
        chk("R4 addr", fall_addr, VEC[i][24:8]);
      end else begin
        chk("R6 read data", rdat, VEC[i][7:0]);
        chk("R6 latency", lat, 5);
        chk("R6 oe width", oe_rec, 4);
      end
      if (i == 7) chk("R7 turnaround gap", gap_rec >= 3, 1);
      chk("R8 idle pins", {mem_ce_n, mem_ce, mem_we_n, mem_dq_oe}, 4'b1010);
    end

    // R2: request changed while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h000AA; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 17'h000CC; req_wdata = 8'h77;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    do_op(1'b0, 17'h000CC, 8'h00, busy, lat, rdat);
    chk("R2 busy request ignored", rdat, 8'h00);
    do_op(1'b0, 17'h000AA, 8'h00, busy, lat, rdat);
    chk("R2 accepted request", rdat, 8'h11);

    // R7: read directly followed by a queued write
    do_op(1'b0, 17'h000AA, 8'h00, busy, lat, rdat);
    do_op(1'b1, 17'h000AB, 8'h22, busy, lat, rdat);
    chk("R7 read-to-write gap", gap_rec >= 3, 1);
    chk("R7 no contention", contention, 0);

    // R1: reset during a write pulse releases write enable at once
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h000AC; req_wdata = 8'h33;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R3 pulse started", mem_we_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async we release", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule